// File: doc/BRIEF.md
# Two-Level Linear Address Translator

This block turns a 32-bit linear address into a physical address by walking a two-level translation structure kept in memory. A translation request is accepted on a valid/ready handshake. The block then reads one 32-bit directory word. The upper 20 bits of that word locate a second-level table, and the block reads one 32-bit table word from it. The upper 20 bits of the table word give the physical frame of a 4096-byte page. The low 12 bits of the linear address pass through as the offset within that page.

Bit 0 of each fetched word marks the entry as present. When a word is not present, the walk stops. The response then carries a fault flag, the level that failed and the linear address that caused the fault. When translation is switched off, the linear address comes back unchanged after one cycle and memory is not touched. Only one walk runs at a time. The memory port has a single outstanding read, and the requester sees the block as busy until the response has been taken.

Top module: `xlw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: A request accepted while `paging_en` is 0 gives `rsp_valid`=1 in the next cycle, with `rsp_addr` equal to the request address and `rsp_fault`=0. No memory read is issued.
- R3: With `paging_en`=1, the first read goes to address {`dir_base`[31:12], lin[31:22], 2'b00}.
- R4: When the directory word has bit 0 set, the second read goes to address {directory word[31:12], lin[21:12], 2'b00}.
- R5: When the table word has bit 0 set, the response is `rsp_fault`=0 with `rsp_addr` = {table word[31:12], lin[11:0]}.
- R6: A directory word with bit 0 clear ends the walk with `rsp_fault`=1, `rsp_lvl`=0 and `rsp_addr` equal to the linear address. No second read is issued.
- R7: A table word with bit 0 clear ends the walk with `rsp_fault`=1, `rsp_lvl`=1 and `rsp_addr` equal to the linear address.
- R8: `req_ready` stays 0 from acceptance until the response is taken (`rsp_valid` and `rsp_ready` both 1). While `rsp_ready` is 0, the response stays valid and unchanged. After the response is taken, `req_ready` returns to 1.
- R9: `mem_req` stays 1 with a stable `mem_addr` until `mem_gnt`. After a grant, `mem_req` stays 0 until `mem_rvalid` returns the word, which arrives at least one cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| paging_en | input | 1 | Translation enable, sampled when a request is accepted |
| dir_base | input | 32 | Physical base of the directory; bits 31:12 are used and sampled on acceptance |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_lin | input | 32 | Linear address to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_addr | output | 32 | Physical address, or the faulting linear address |
| rsp_fault | output | 1 | Walk ended on an entry that is not present |
| rsp_lvl | output | 1 | Failing level: 0 for the directory, 1 for the table |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_gnt | input | 1 | Memory accepts the read |
| mem_rvalid | input | 1 | Read word returned |
| mem_rdata | input | 32 | Returned word |

## Verification
Several hundred linear addresses are swept. They step the directory index and the table index through many values and pass distinct page offsets. The memory model computes each entry arithmetically from its address, so the bench can check both read addresses and the final frame independently, and each index field is confirmed to land in the right read. A subset of the entries is not present at each level, which separates directory faults from table faults: a directory fault must skip the second read. Requests with translation off are interleaved, and grant and response back-pressure of varying length is applied, so that the bypass timing and the hold rules can be told apart from the normal walk.

// File: rtl/xlw_pkg.sv
package xlw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DIR_RD = 3'd1,
        ST_DIR_WT = 3'd2,
        ST_TBL_RD = 3'd3,
        ST_TBL_WT = 3'd4,
        ST_RESP   = 3'd5
    } xlw_state_e;

    localparam logic LVL_DIR = 1'b0;
    localparam logic LVL_TBL = 1'b1;

endpackage

// File: rtl/xlw_entry_dec.sv
module xlw_entry_dec #(
    parameter int AW    = 32,
    parameter int OFS_W = 12
) (
    input  logic [AW-1:0]       entry,
    output logic                present,
    output logic [AW-OFS_W-1:0] frame
);
    logic unused_bits;

    assign present     = entry[0];
    assign frame       = entry[AW-1:OFS_W];
    assign unused_bits = ^entry[OFS_W-1:1];
endmodule

// File: rtl/xlw_addr_gen.sv
module xlw_addr_gen #(
    parameter int AW    = 32,
    parameter int OFS_W = 12
) (
    input  logic [AW-OFS_W-1:0] base_frame,
    input  logic [AW-1:0]       lin,
    input  logic                second_lvl,
    output logic [AW-1:0]       addr
);
    localparam int IDX_W  = (AW - OFS_W) / 2;
    localparam int ENT_SH = OFS_W - IDX_W;

    logic [IDX_W-1:0] idx;
    logic             unused_bits;

    always_comb begin
        if (second_lvl) idx = lin[OFS_W+IDX_W-1:OFS_W];
        else            idx = lin[OFS_W+2*IDX_W-1:OFS_W+IDX_W];
    end

    assign addr        = {base_frame, idx, {ENT_SH{1'b0}}};
    assign unused_bits = ^lin[OFS_W-1:0];
endmodule

// File: rtl/xlw_walker.sv
module xlw_walker #(
    parameter int AW    = 32,
    parameter int OFS_W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          paging_en,
    input  logic [AW-1:0] dir_base,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_lin,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [AW-1:0] rsp_addr,
    output logic          rsp_fault,
    output logic          rsp_lvl,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [AW-1:0] mem_rdata
);
    import xlw_pkg::*;

    localparam int FR_W = AW - OFS_W;

    typedef struct packed {
        xlw_state_e      st;
        logic [AW-1:0]   lin;
        logic [FR_W-1:0] base;
        logic [AW-1:0]   out;
        logic            fault;
        logic            lvl;
    } walk_s;

    walk_s           s_d, s_q;
    logic            ent_present;
    logic [FR_W-1:0] ent_frame;
    logic            unused_base;

    assign unused_base = ^dir_base[OFS_W-1:0];

    xlw_entry_dec #(.AW(AW), .OFS_W(OFS_W)) dec_i (
        .entry   (mem_rdata),
        .present (ent_present),
        .frame   (ent_frame)
    );

    xlw_addr_gen #(.AW(AW), .OFS_W(OFS_W)) agen_i (
        .base_frame (s_q.base),
        .lin        (s_q.lin),
        .second_lvl (s_q.st == ST_TBL_RD),
        .addr       (mem_addr)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.lin   = req_lin;
                    s_d.base  = dir_base[AW-1:OFS_W];
                    s_d.fault = 1'b0;
                    s_d.lvl   = LVL_DIR;
                    if (paging_en) begin
                        s_d.st = ST_DIR_RD;
                    end else begin
                        s_d.out = req_lin;
                        s_d.st  = ST_RESP;
                    end
                end
            end
            ST_DIR_RD: if (mem_gnt) s_d.st = ST_DIR_WT;
            ST_DIR_WT: begin
                if (mem_rvalid) begin
                    if (ent_present) begin
                        s_d.base = ent_frame;
                        s_d.st   = ST_TBL_RD;
                    end else begin
                        s_d.fault = 1'b1;
                        s_d.lvl   = LVL_DIR;
                        s_d.out   = s_q.lin;
                        s_d.st    = ST_RESP;
                    end
                end
            end
            ST_TBL_RD: if (mem_gnt) s_d.st = ST_TBL_WT;
            ST_TBL_WT: begin
                if (mem_rvalid) begin
                    if (ent_present) begin
                        s_d.out = {ent_frame, s_q.lin[OFS_W-1:0]};
                    end else begin
                        s_d.fault = 1'b1;
                        s_d.lvl   = LVL_TBL;
                        s_d.out   = s_q.lin;
                    end
                    s_d.st = ST_RESP;
                end
            end
            ST_RESP: if (rsp_ready) s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, lin: '0, base: '0, out: '0, fault: 1'b0, lvl: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = (s_q.st == ST_IDLE);
    assign rsp_valid = (s_q.st == ST_RESP);
    assign rsp_addr  = s_q.out;
    assign rsp_fault = s_q.fault;
    assign rsp_lvl   = s_q.lvl;
    assign mem_req   = (s_q.st == ST_DIR_RD) || (s_q.st == ST_TBL_RD);
endmodule

// File: rtl/xlw_walk_chk.sv
module xlw_walk_chk #(
    parameter int AW    = 32,
    parameter int OFS_W = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          paging_en,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_lin,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic [AW-1:0] rsp_addr,
    input logic          rsp_fault,
    input logic          rsp_lvl,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_gnt
);
    localparam int IDX_W  = (AW - OFS_W) / 2;
    localparam int ENT_SH = OFS_W - IDX_W;

    logic [AW-1:0] lin_cap;
    logic [1:0]    rd_cnt;
    logic          acc;

    assign acc = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lin_cap <= '0;
            rd_cnt  <= '0;
        end else if (acc) begin
            lin_cap <= req_lin;
            rd_cnt  <= '0;
        end else if (mem_req && mem_gnt && rd_cnt != 2'd3) begin
            rd_cnt  <= rd_cnt + 2'd1;
        end
    end

    AST_BYPASS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !paging_en |=> rsp_valid && !rsp_fault && rsp_addr == $past(req_lin)); // R2
    AST_BYPASS_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !paging_en |=> !mem_req); // R2
    AST_DIR_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && rd_cnt == 2'd0 |-> mem_addr[OFS_W-1:ENT_SH] == lin_cap[AW-1:OFS_W+IDX_W]); // R3
    AST_TBL_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && rd_cnt == 2'd1 |-> mem_addr[OFS_W-1:ENT_SH] == lin_cap[OFS_W+IDX_W-1:OFS_W]); // R4
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> rsp_addr[OFS_W-1:0] == lin_cap[OFS_W-1:0]); // R5
    AST_FAULT_LIN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_addr == lin_cap); // R6
    AST_DIR_FAULT_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault && !rsp_lvl |-> rd_cnt == 2'd1); // R6
    AST_TBL_FAULT_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault && rsp_lvl |-> rd_cnt == 2'd2); // R7
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_fault) && $stable(rsp_lvl)); // R8
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_req) |-> !req_ready); // R8
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr)); // R9
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_gnt |=> !mem_req); // R9
endmodule

bind xlw_walker xlw_walk_chk #(.AW(AW), .OFS_W(OFS_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .paging_en (paging_en),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_lin   (req_lin),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_addr  (rsp_addr),
    .rsp_fault (rsp_fault),
    .rsp_lvl   (rsp_lvl),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_gnt   (mem_gnt)
);

// File: tb/xlw_walker_tb.sv
module xlw_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        paging_en = 1'b0;
    logic [31:0] dir_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_addr;
    logic        rsp_fault;
    logic        rsp_lvl;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    xlw_walker dut_i (
        .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .dir_base(dir_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
        .rsp_fault(rsp_fault), .rsp_lvl(rsp_lvl), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Directory entries: not present when address bits 5:2 are all ones.
    function automatic logic [31:0] dir_word(input logic [31:0] a);
        logic [19:0] fr;
        fr = a[31:12] ^ {a[11:2], 10'h15A};
        return {fr, 11'h0, (a[5:2] != 4'hF)};
    endfunction

    // Table entries: not present when address bits 6:2 are all ones.
    function automatic logic [31:0] tbl_word(input logic [31:0] a);
        logic [19:0] fr;
        fr = ~a[31:12] + {10'h0, a[11:2]};
        return {fr, 11'h2A6, (a[6:2] != 5'h1F)};
    endfunction

    task automatic serve(input logic [31:0] exp_addr, input logic [31:0] data,
                         input int stall, input string req);
        int n = 0;
        while (!mem_req && n < 8) begin @(negedge clk); n++; end
        chk(mem_req == 1'b1, "R9 read issued", {31'h0, mem_req}, 32'h1);
        chk(mem_addr == exp_addr, req, mem_addr, exp_addr);
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            chk(mem_req && mem_addr == exp_addr, "R9 held until grant", mem_addr, exp_addr);
        end
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        chk(!mem_req, "R9 single outstanding", {31'h0, mem_req}, 32'h0);
        mem_rvalid = 1'b1;
        mem_rdata  = data;
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata  = 32'hDEAD_BEEF;
    endtask

    task automatic take_rsp(input logic [31:0] e_addr, input logic e_fault, input logic e_lvl,
                            input int stall, input string req);
        int n = 0;
        while (!rsp_valid && n < 8) begin @(negedge clk); n++; end
        chk(rsp_valid == 1'b1, req, {31'h0, rsp_valid}, 32'h1);
        chk(rsp_addr == e_addr, req, rsp_addr, e_addr);
        chk(rsp_fault == e_fault, req, {31'h0, rsp_fault}, {31'h0, e_fault});
        if (e_fault) chk(rsp_lvl == e_lvl, req, {31'h0, rsp_lvl}, {31'h0, e_lvl});
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_addr == e_addr && !req_ready, "R8 hold while not taken", rsp_addr, e_addr);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R8 idle after take", {30'h0, rsp_valid, req_ready}, 32'h1);
    endtask

    task automatic walk(input logic [31:0] lin, input logic [31:0] dbase, input bit pg, input int stall);
        logic [31:0] da, dw, ta, tw;
        req_valid = 1'b1;
        req_lin   = lin;
        dir_base  = dbase;
        paging_en = pg;
        @(negedge clk);
        req_valid = 1'b0;
        paging_en = ~pg;
        dir_base  = ~dbase;
        chk(!req_ready, "R8 busy after accept", {31'h0, req_ready}, 32'h0);
        if (!pg) begin
            chk(rsp_valid && !mem_req, "R2 bypass next cycle", {30'h0, rsp_valid, mem_req}, 32'h2);
            take_rsp(lin, 1'b0, 1'b0, stall, "R2 bypass address");
        end else begin
            da = {dbase[31:12], lin[31:22], 2'b00};
            dw = dir_word(da);
            serve(da, dw, stall, "R3 directory read address");
            if (!dw[0]) begin
                @(negedge clk);
                chk(!mem_req, "R6 no table read", {31'h0, mem_req}, 32'h0);
                take_rsp(lin, 1'b1, 1'b0, stall, "R6 directory fault");
            end else begin
                ta = {dw[31:12], lin[21:12], 2'b00};
                tw = tbl_word(ta);
                serve(ta, tw, stall, "R4 table read address");
                if (tw[0]) take_rsp({tw[31:12], lin[11:0]}, 1'b0, 1'b0, stall, "R5 physical address");
                else       take_rsp(lin, 1'b1, 1'b1, stall, "R7 table fault");
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req, "R1 reset state",
            {29'h0, req_ready, rsp_valid, mem_req}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        walk(32'h0000_0000, 32'h0010_0000, 1'b1, 0);
        walk(32'hFFFF_FFFF, 32'h0010_0000, 1'b1, 1);
        walk(32'hFF9F_F123, 32'h00AB_C000, 1'b1, 2);
        walk(32'hFFBF_FABC, 32'h0123_4FFF, 1'b1, 0);
        walk(32'h1234_5678, 32'h0, 1'b0, 0);
        walk(32'hFFFF_FFFF, 32'h0, 1'b0, 3);
        for (int i = 0; i < 400; i++) begin
            logic [31:0] lin;
            logic [31:0] db;
            lin = i * 32'h0251_3F17 + 32'h0040_1000;
            db  = {i[7:0], 24'h5A3_000} ^ 32'h8000_0000;
            walk(lin, db, (i % 5) != 4, i % 3);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule